// File: doc/BRIEF.md
# Program/Verify Address Counter

This block holds the word pointer a small microcontroller uses while it is held in serial program/verify mode. The pointer is 14 bits wide and spans a 16K-word space. Its lower half is user program memory and its upper half is configuration memory. A serial front end, which lies outside this block, decodes commands and raises one-cycle strobes. A mode-entry strobe clears the pointer, a configuration strobe forces it to the base of the upper half, and an increment strobe advances it. A level input says whether the current command targets program storage or the data byte array.

Once the pointer reaches the upper half it stays there. Incrementing wraps inside that half, and only a fresh mode entry brings it back to user space. Besides the logical pointer, the block produces a storage select, a physical word address and a location class. These fold the logical value onto the small arrays that really exist: 1K user words, 16 configuration words and 64 data bytes. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `pac_top`

## Requirements
- R1: After an asynchronous reset, or on the clock edge after an `enter_i` pulse, `pc_o` is 0x0000 and the block points at user program memory.
- R2: A `cfg_jump_i` strobe loads `pc_o` with 0x2000.
- R3: An `incr_i` strobe advances `pc_o` by one. 0x1FFF steps to 0x2000, and 0x3FFF wraps to 0x2000, never to 0x0000.
- R4: Once `pc_o[13]` is set, it stays set under any sequence of increments and jumps until `enter_i` is pulsed.
- R5: With `tgt_data_i`=0 and `pc_o` outside 0x2000–0x200F, `mem_sel_o` is 2'b00 (user array) and `phys_addr_o` equals `pc_o[9:0]`, so bits 12..10 are ignored.
- R6: With `tgt_data_i`=0 and `pc_o` in 0x2000–0x200F, `mem_sel_o` is 2'b01 (configuration array) and `phys_addr_o` equals `pc_o[3:0]`, zero-extended.
- R7: With `tgt_data_i`=0 and `pc_o` in 0x2010–0x3FFF, the user array is selected (2'b00) with `phys_addr_o` = `pc_o[9:0]`.
- R8: With `tgt_data_i`=1, `mem_sel_o` is 2'b10 (data array) and `phys_addr_o` equals `pc_o[5:0]`, zero-extended, whatever the upper pointer bits are.
- R9: `loc_kind_o` is 2'b00 for ID words 0x2000–0x2003, 2'b01 for reserved words 0x2004–0x2006 and 2'b10 for the configuration word 0x2007. In every other case, including whenever the data target is selected, it is 2'b11.
- R10: `enter_i` takes priority over `cfg_jump_i`, and `cfg_jump_i` takes priority over `incr_i` when they arrive in the same cycle.
- R11: Outputs change only on the clock edge that samples a strobe or a new `tgt_data_i`. Between edges they hold their previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enter_i | input | 1 | Mode-entry pulse; clears the pointer |
| cfg_jump_i | input | 1 | Strobe that moves the pointer to configuration base 0x2000 |
| incr_i | input | 1 | Increment strobe |
| tgt_data_i | input | 1 | 1 = data byte array targeted, 0 = program storage |
| pc_o | output | 14 | Logical pointer |
| mem_sel_o | output | 2 | 00 user, 01 configuration, 10 data |
| phys_addr_o | output | 10 | Physical word address in the selected array |
| loc_kind_o | output | 2 | 00 ID, 01 reserved, 10 configuration word, 11 other |

## Verification
Long increment walks cover both halves of the space end to end. They show the carry into bit 13 and the wrap at 0x3FFF, and they show aliasing of user addresses above 0x3FF onto the 1K array. Stepping one word at a time through 0x2000–0x2010 separates the ID, reserved, configuration-word and test classes from the fold-back into user memory just past the implemented window. Same-cycle strobe pairs check the priority order. Toggling the data target at pointer values above 0x3F and inside configuration space checks that only the low six bits reach the data array. A probe between edges confirms that nothing moves before the clock.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [1:0] {
    SEL_USER = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_DATA = 2'b10
  } mem_sel_e;

  typedef enum logic [1:0] {
    LOC_ID   = 2'b00,
    LOC_RSVD = 2'b01,
    LOC_CFGW = 2'b10,
    LOC_NONE = 2'b11
  } loc_kind_e;
endpackage

// File: rtl/pac_pc_core.sv
module pac_pc_core #(
  parameter int PC_W = 14
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            enter_i,
  input  logic            jump_i,
  input  logic            incr_i,
  output logic [PC_W-1:0] pc_d_o,
  output logic [PC_W-1:0] pc_q_o
);
  localparam int HI = PC_W - 1;
  localparam logic [PC_W-1:0] CFG_BASE = PC_W'(1) << HI;
  localparam logic [PC_W-1:0] TOP_PC   = '1;

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (enter_i)     pc_d = '0;
    else if (jump_i) pc_d = CFG_BASE;
    else if (incr_i) begin
      pc_d = pc_q + PC_W'(1);
      // upper half is a trap: carry out of the top wraps to its base
      if (pc_q[HI]) pc_d[HI] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_d_o = pc_d;
  assign pc_q_o = pc_q;

  p_enter_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_i |=> pc_q == '0);
  p_jump_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !enter_i) |=> pc_q == CFG_BASE);
  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !jump_i && !enter_i && pc_q != TOP_PC) |=> pc_q == $past(pc_q) + PC_W'(1));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (incr_i && !jump_i && !enter_i && pc_q == TOP_PC) |=> pc_q == CFG_BASE);
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q[HI] && !enter_i) |=> pc_q[HI]);
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enter_i && !jump_i && !incr_i) |=> $stable(pc_q));
endmodule

// File: rtl/pac_addr_map.sv
module pac_addr_map
  import pac_pkg::*;
#(
  parameter int PC_W    = 14,
  parameter int USER_AW = 10,
  parameter int CFG_AW  = 4,
  parameter int DATA_AW = 6,
  parameter int ID_N    = 4,
  parameter int CFGW_IX = 7,
  parameter int PHYS_W  = 10
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic              tgt_data_i,
  output mem_sel_e          sel_o,
  output logic [PHYS_W-1:0] phys_o,
  output loc_kind_e         kind_o
);
  localparam int HI = PC_W - 1;

  logic              cfg_hit;
  logic [CFG_AW-1:0] cix;

  assign cfg_hit = pc_i[HI] && (pc_i[HI-1:CFG_AW] == '0);
  assign cix     = pc_i[CFG_AW-1:0];

  always_comb begin
    sel_o  = SEL_USER;
    phys_o = PHYS_W'(pc_i[USER_AW-1:0]);
    kind_o = LOC_NONE;
    if (tgt_data_i) begin
      sel_o  = SEL_DATA;
      phys_o = PHYS_W'(pc_i[DATA_AW-1:0]);
    end else if (cfg_hit) begin
      sel_o  = SEL_CFG;
      phys_o = PHYS_W'(cix);
      if (cix < CFG_AW'(ID_N))         kind_o = LOC_ID;
      else if (cix < CFG_AW'(CFGW_IX)) kind_o = LOC_RSVD;
      else if (cix == CFG_AW'(CFGW_IX)) kind_o = LOC_CFGW;
    end
  end
endmodule

// File: rtl/pac_top.sv
module pac_top
  import pac_pkg::*;
#(
  parameter int PC_W    = 14,
  parameter int USER_AW = 10,
  parameter int CFG_AW  = 4,
  parameter int DATA_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enter_i,
  input  logic               cfg_jump_i,
  input  logic               incr_i,
  input  logic               tgt_data_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [1:0]         mem_sel_o,
  output logic [USER_AW-1:0] phys_addr_o,
  output logic [1:0]         loc_kind_o
);
  localparam int PHYS_W = USER_AW;
  localparam int HI     = PC_W - 1;
  localparam logic [PC_W-1:0] CFGW_PC = (PC_W'(1) << HI) | PC_W'(7);

  logic [PC_W-1:0]   pc_d, pc_q;
  mem_sel_e          sel_d;
  loc_kind_e         kind_d;
  logic [PHYS_W-1:0] phys_d;
  mem_sel_e          sel_q;
  loc_kind_e         kind_q;
  logic [PHYS_W-1:0] phys_q;

  pac_pc_core #(.PC_W(PC_W)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .enter_i(enter_i),
    .jump_i (cfg_jump_i),
    .incr_i (incr_i),
    .pc_d_o (pc_d),
    .pc_q_o (pc_q)
  );

  // decode the next pointer so every output lands on the same edge
  pac_addr_map #(
    .PC_W(PC_W), .USER_AW(USER_AW), .CFG_AW(CFG_AW), .DATA_AW(DATA_AW),
    .ID_N(4), .CFGW_IX(7), .PHYS_W(PHYS_W)
  ) u_map (
    .pc_i      (pc_d),
    .tgt_data_i(tgt_data_i),
    .sel_o     (sel_d),
    .phys_o    (phys_d),
    .kind_o    (kind_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= SEL_USER;
      phys_q <= '0;
      kind_q <= LOC_NONE;
    end else begin
      sel_q  <= sel_d;
      phys_q <= phys_d;
      kind_q <= kind_d;
    end
  end

  assign pc_o        = pc_q;
  assign mem_sel_o   = sel_q;
  assign phys_addr_o = phys_q;
  assign loc_kind_o  = kind_q;

  p_data_fold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_data_i |=> (mem_sel_o == SEL_DATA) && (phys_addr_o[PHYS_W-1:DATA_AW] == '0));
  p_cfg_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sel_o == SEL_CFG) |-> (pc_o[HI] && pc_o[HI-1:CFG_AW] == '0));
  p_cfgw_class_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_kind_o == LOC_CFGW) |-> (pc_o == CFGW_PC && mem_sel_o == SEL_CFG));
  p_user_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sel_o == SEL_USER) |-> (phys_addr_o == pc_o[USER_AW-1:0]));
endmodule

// File: tb/sim_pac_top.sv
`timescale 1ns/1ps
module sim_pac_top;
  typedef struct {
    logic [13:0] pc;
    logic [1:0]  sel;
    logic [9:0]  addr;
    logic [1:0]  kind;
    string       req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic enter = 0, jump = 0, incr = 0, tgt = 0;
  logic [13:0] pc_o;
  logic [1:0]  sel_o, kind_o;
  logic [9:0]  addr_o;

  int vecs = 0, errs = 0;
  logic [13:0] mpc = '0;
  logic        mtgt = 0;
  exp_t        exp_q[$];

  always #10 clk = ~clk;

  pac_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .enter_i(enter), .cfg_jump_i(jump),
    .incr_i(incr), .tgt_data_i(tgt), .pc_o(pc_o), .mem_sel_o(sel_o),
    .phys_addr_o(addr_o), .loc_kind_o(kind_o)
  );

  function automatic exp_t model(logic [13:0] p, logic d, string r);
    exp_t e;
    logic cw;
    cw = p[13] && (p[12:4] == 9'd0);
    e.pc  = p;
    e.req = r;
    e.kind = 2'b11;
    if (d) begin
      e.sel = 2'b10; e.addr = {4'd0, p[5:0]};
    end else if (cw) begin
      e.sel = 2'b01; e.addr = {6'd0, p[3:0]};
      if (p[3:0] < 4)       e.kind = 2'b00;
      else if (p[3:0] < 7)  e.kind = 2'b01;
      else if (p[3:0] == 7) e.kind = 2'b10;
    end else begin
      e.sel = 2'b00; e.addr = p[9:0];
    end
    return e;
  endfunction

  task automatic compare(exp_t e);
    vecs++;
    if (pc_o !== e.pc || sel_o !== e.sel || addr_o !== e.addr || kind_o !== e.kind) begin
      errs++;
      $display("FAIL %s: pc/sel/addr/kind got %h/%b/%h/%b exp %h/%b/%h/%b",
               e.req, pc_o, sel_o, addr_o, kind_o, e.pc, e.sel, e.addr, e.kind);
    end
  endtask

  // monitor: one expected item per active edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) compare(exp_q.pop_front());
  end

  task automatic step(logic en, logic jp, logic inc, logic tg, string r);
    @(negedge clk);
    compare(model(mpc, mtgt, "R11 hold before edge"));
    enter = en; jump = jp; incr = inc; tgt = tg;
    if (en)       mpc = 14'h0000;
    else if (jp)  mpc = 14'h2000;
    else if (inc) mpc = (mpc == 14'h3FFF) ? 14'h2000 : mpc + 14'd1;
    mtgt = tg;
    exp_q.push_back(model(mpc, mtgt, r));
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #45;
    compare(model(14'h0000, 1'b0, "R1 reset state"));
    @(negedge clk); rst_n = 1;
    step(1, 0, 0, 0, "R1 enter");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, "R3 step/R5");
    step(0, 0, 0, 1, "R8 data at low pc");
    step(0, 0, 0, 0, "R11 idle hold");
    // user walk to the top of the lower half, checks aliasing on the way
    while (mpc != 14'h1FFF) step(0, 0, 1, 0, "R3 walk/R5 alias");
    step(0, 0, 0, 1, "R8 data above 0x3F");
    step(0, 0, 1, 0, "R3 carry into 0x2000/R9 ID");
    for (int i = 0; i < 17; i++) step(0, 0, 1, 0, "R6 R9 R7 cfg window");
    step(0, 0, 0, 1, "R8 R9 data in cfg space");
    step(0, 1, 1, 0, "R10 jump beats incr");
    for (int i = 0; i < 7; i++) step(0, 0, 1, 0, "R9 to cfg word");
    step(0, 0, 0, 1, "R8 data at 0x2007");
    step(0, 0, 0, 0, "R9 cfg word class");
    step(1, 1, 1, 0, "R10 enter beats jump");
    step(0, 1, 0, 0, "R2 jump");
    while (mpc != 14'h3FFF) step(0, 0, 1, 0, "R4 sticky/R7 upper alias");
    step(0, 0, 1, 0, "R3 wrap to 0x2000");
    step(0, 0, 1, 0, "R4 stays high");
    step(1, 0, 0, 0, "R4 R1 only enter returns");
    step(0, 0, 0, 0, "R11 idle");
    @(negedge clk); enter = 0; jump = 0; incr = 0; tgt = 0;
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule